// File: doc/BRIEF.md
# Fuse Array Byte Read Sequencer

This block turns one host request into a complete, power-managed read of a one-time-programmable fuse array. A request carries a start address and a byte count. The block first brings the fuse power domain up in a fixed order with a settle delay. It then reads the bytes one at a time through a request/ready handshake with the array controller and streams each byte out with a one-cycle valid strobe. Last, it takes the domain back down in the reverse order and pulses `done`.

Each byte read has its own ready timeout. If ready does not arrive in time, the block stops reading, still runs the full power-down, and then raises `err_timeout` in the same cycle as `done`. A request with a count of zero finishes at once and leaves the power and fuse outputs alone. While a sequence runs, `busy` is high and further requests are dropped.

The controller has fourteen states:

- Idle. On start it goes to Finish if the length is zero, or to PuMask otherwise.
- Power-up chain: PuMask, PuEnA, PuWait, PuEnB, PuUnIso. PuWait leaves when the settle timer expires. PuUnIso leads to RdIssue.
- Read loop: RdIssue, then RdPoll. On ready, RdPoll returns to RdIssue for the next byte, or goes to PdIso after the last byte. If the poll timer expires first, RdPoll goes to PdIso.
- Power-down chain: PdIso, PdEnB, PdWait, PdEnA, PdUnmask, then Finish. PdWait leaves when the settle timer expires.
- Finish always returns to Idle.

Top module: `otp_rd_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, `byte_valid`, `done`, `err_timeout`, `fuse_req`, `pwr_wmask`, `pwr_en_a` and `pwr_en_b` are 0, and `pwr_iso` is 1 (isolated).
- R2: Power-up ordering and timing, counted from the cycle in which `req_start` is sampled high (cycle t):
  - `pwr_wmask` rises in cycle t+2.
  - `pwr_en_a` rises one cycle after `pwr_wmask`.
  - `pwr_en_b` rises SETTLE_CYCLES+1 cycles after `pwr_en_a`.
  - `pwr_iso` falls one cycle after `pwr_en_b` rises.
  - The first `fuse_req` is in that same cycle.
- R3: Each byte is read by a one-cycle `fuse_req` carrying `fuse_addr`, and only while the domain is powered and not isolated. `fuse_rdy` is ignored in the request cycle, so stale ready is never taken. The byte is `fuse_rdata` from the first later cycle with `fuse_rdy` high, and it appears on `byte_data` with `byte_valid` one cycle after that.
- R4: Addresses run upward from the start address to start+count-1. Exactly count bytes are streamed, each with a single `byte_valid` pulse, and `byte_valid` is never high together with `done`.
- R5: Power-down ordering and timing:
  - `pwr_iso` rises one cycle after the last `byte_valid`.
  - `pwr_en_b` falls one cycle later.
  - `pwr_en_a` falls SETTLE_CYCLES+1 cycles after that.
  - `pwr_wmask` falls one cycle after `pwr_en_a`.
  - `done` pulses for one cycle, one cycle after `pwr_wmask` falls.
  - At `done`, all power controls are off and isolation is on.
- R6: If `fuse_rdy` stays low for POLL_LIMIT cycles after a request:
  - No further byte or request follows.
  - `pwr_iso` rises POLL_LIMIT+2 cycles after that request.
  - The R5 power-down runs.
  - `done` pulses with `err_timeout` high. `err_timeout` is never high without `done`.
- R7: Ready first seen on the POLL_LIMIT-th poll cycle, which is the cycle in which the timeout would fire, is accepted as a good byte.
- R8: A request with count 0 gives a `done` pulse two cycles after `req_start` is sampled, with `err_timeout` low. It issues no `fuse_req` and changes no power or isolation output.
- R9: `busy` is high from the cycle after an accepted start until the sequence returns to Idle. A `req_start` while busy has no effect on the addresses read, the byte count, or the number of `done` pulses.
- R10: `err_timeout` is low at the `done` of a fully successful request, even when the previous request timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start pulse, taken only in Idle |
| req_addr | input | AW | First fuse byte address |
| req_len | input | LW | Number of bytes to read |
| busy | output | 1 | Sequence in progress |
| byte_valid | output | 1 | Strobe for one streamed byte |
| byte_data | output | 8 | Streamed byte |
| done | output | 1 | One-cycle end-of-request pulse |
| err_timeout | output | 1 | Ready timeout; high only with done |
| fuse_req | output | 1 | Read request to the array controller (clears its ready) |
| fuse_addr | output | AW | Address of the byte being read |
| fuse_rdy | input | 1 | Controller ready bit |
| fuse_rdata | input | 8 | Low byte of the controller status word |
| pwr_wmask | output | 1 | Power-control write-mask override |
| pwr_en_a | output | 1 | Fuse power enable, first stage |
| pwr_en_b | output | 1 | Fuse power enable, second stage |
| pwr_iso | output | 1 | Isolation between fuse domain and core (1 = isolated) |

## Verification
Ready arrival and poll-timeout expiry can fall in the same RdPoll cycle. The bench provokes this with a fuse model whose ready latency equals POLL_LIMIT-1 poll cycles. It judges the outcome by the full byte count, correct byte values, and `err_timeout` staying low (R7). One extra cycle of latency is the contrasting case: it must abort with the error flag set. A second overlap is a new `req_start` arriving while the read loop runs. It is judged by the request count, the streamed bytes and the single `done` pulse.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_MASK,
        ST_PU_ENA,
        ST_PU_WAIT,
        ST_PU_ENB,
        ST_PU_UNISO,
        ST_RD_ISSUE,
        ST_RD_POLL,
        ST_PD_ISO,
        ST_PD_ENB,
        ST_PD_WAIT,
        ST_PD_ENA,
        ST_PD_UNMASK,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && run && !clr) |=> expired);

endmodule

// File: rtl/otp_addr_walker.sv
module otp_addr_walker #(
    parameter int unsigned AW = 10,
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] count,
    output logic [AW-1:0] cur_addr,
    output logic          last
);
    logic [AW-1:0] addr_q;
    logic [LW-1:0] left_q;

    assign cur_addr = addr_q;
    assign last     = (left_q == LW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= start_addr;
            left_q <= count;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    // R4
    walk_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left_q != '0));

endmodule

// File: rtl/otp_rd_seq.sv
module otp_rd_seq
    import otp_seq_pkg::*;
#(
    parameter int unsigned AW            = 10,
    parameter int unsigned LW            = 8,
    parameter int unsigned SETTLE_CYCLES = 250000,
    parameter int unsigned POLL_LIMIT    = 250000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          busy,
    output logic          byte_valid,
    output logic [7:0]    byte_data,
    output logic          done,
    output logic          err_timeout,
    output logic          fuse_req,
    output logic [AW-1:0] fuse_addr,
    input  logic          fuse_rdy,
    input  logic [7:0]    fuse_rdata,
    output logic          pwr_wmask,
    output logic          pwr_en_a,
    output logic          pwr_en_b,
    output logic          pwr_iso
);
    localparam int unsigned GW = $clog2(SETTLE_CYCLES + 1);

    seq_state_t state_q, state_d;
    logic settle_hit, poll_hit, walk_last, fail_q;
    logic [AW-1:0] walk_addr;

    // ---------------- helpers ----------------
    otp_addr_walker #(.AW(AW), .LW(LW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == ST_IDLE && req_start),
        .step       (state_q == ST_RD_POLL && fuse_rdy),
        .start_addr (req_addr),
        .count      (req_len),
        .cur_addr   (walk_addr),
        .last       (walk_last)
    );

    otp_cycle_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_PU_ENA || state_q == ST_PD_ENB),
        .run     (state_q == ST_PU_WAIT || state_q == ST_PD_WAIT),
        .expired (settle_hit)
    );

    otp_cycle_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_RD_ISSUE),
        .run     (state_q == ST_RD_POLL),
        .expired (poll_hit)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_start) state_d = (req_len == '0) ? ST_FINISH : ST_PU_MASK;
            ST_PU_MASK:   state_d = ST_PU_ENA;
            ST_PU_ENA:    state_d = ST_PU_WAIT;
            ST_PU_WAIT:   if (settle_hit) state_d = ST_PU_ENB;
            ST_PU_ENB:    state_d = ST_PU_UNISO;
            ST_PU_UNISO:  state_d = ST_RD_ISSUE;
            ST_RD_ISSUE:  state_d = ST_RD_POLL;
            ST_RD_POLL: begin
                if (fuse_rdy)      state_d = walk_last ? ST_PD_ISO : ST_RD_ISSUE;
                else if (poll_hit) state_d = ST_PD_ISO;
            end
            ST_PD_ISO:    state_d = ST_PD_ENB;
            ST_PD_ENB:    state_d = ST_PD_WAIT;
            ST_PD_WAIT:   if (settle_hit) state_d = ST_PD_ENA;
            ST_PD_ENA:    state_d = ST_PD_UNMASK;
            ST_PD_UNMASK: state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    assign busy      = (state_q != ST_IDLE);
    assign fuse_req  = (state_q == ST_RD_ISSUE);
    assign fuse_addr = walk_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_wmask   <= 1'b0;
            pwr_en_a    <= 1'b0;
            pwr_en_b    <= 1'b0;
            pwr_iso     <= 1'b1;
            byte_valid  <= 1'b0;
            byte_data   <= '0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            byte_valid  <= 1'b0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            unique case (state_q)
                ST_IDLE:      if (req_start) fail_q <= 1'b0;
                ST_PU_MASK:   pwr_wmask <= 1'b1;
                ST_PU_ENA:    pwr_en_a  <= 1'b1;
                ST_PU_ENB:    pwr_en_b  <= 1'b1;
                ST_PU_UNISO:  pwr_iso   <= 1'b0;
                ST_RD_POLL: begin
                    if (fuse_rdy) begin
                        byte_valid <= 1'b1;
                        byte_data  <= fuse_rdata;
                    end else if (poll_hit) begin
                        fail_q <= 1'b1;
                    end
                end
                ST_PD_ISO:    pwr_iso   <= 1'b1;
                ST_PD_ENB:    pwr_en_b  <= 1'b0;
                ST_PD_ENA:    pwr_en_a  <= 1'b0;
                ST_PD_UNMASK: pwr_wmask <= 1'b0;
                ST_FINISH: begin
                    done        <= 1'b1;
                    err_timeout <= fail_q;
                end
                default: ;
            endcase
        end
    end

    // ---------------- checks ----------------
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_en_a)                                  gap_q <= '0;
        else if (!pwr_en_b && gap_q != GW'(SETTLE_CYCLES))        gap_q <= gap_q + 1'b1;
    end

    // R2
    pu_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_b) |-> (pwr_en_a && pwr_wmask));

    // R2
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_b) |-> (gap_q == GW'(SETTLE_CYCLES)));

    // R3
    req_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req |-> (!pwr_iso && pwr_en_b && pwr_en_a));

    // R4
    valid_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !done);

    // R5
    pd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_a) |-> (pwr_iso && !pwr_en_b));

    // R5
    done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pwr_iso && !pwr_en_a && !pwr_en_b && !pwr_wmask));

    // R6
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> done);

endmodule

// File: tb/otp_rd_seq_tb.sv
`timescale 1ns/1ps
module otp_rd_seq_tb;
    localparam int AW = 10;
    localparam int LW = 8;
    localparam int ST = 8;
    localparam int PL = 16;
    localparam int NV = 7;
    // {addr[9:0], len[7:0], latency[7:0], stuck offset[7:0] (FF = none)}
    localparam logic [33:0] VEC [NV] = '{
        {10'h000, 8'd4,  8'd1,  8'hFF},
        {10'h3FC, 8'd4,  8'd3,  8'hFF},
        {10'h155, 8'd9,  8'd15, 8'hFF},
        {10'h020, 8'd1,  8'd0,  8'hFF},
        {10'h0A0, 8'd3,  8'd16, 8'hFF},
        {10'h100, 8'd6,  8'd2,  8'd3 },
        {10'h2F0, 8'd20, 8'd5,  8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic busy, byte_valid, done, err_timeout, fuse_req;
    logic [7:0] byte_data;
    logic [AW-1:0] fuse_addr;
    logic fuse_rdy;
    logic [7:0] fuse_rdata;
    logic pwr_wmask, pwr_en_a, pwr_en_b, pwr_iso;

    always #2 clk = ~clk;

    otp_rd_seq #(.AW(AW), .LW(LW), .SETTLE_CYCLES(ST), .POLL_LIMIT(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .byte_valid(byte_valid), .byte_data(byte_data),
        .done(done), .err_timeout(err_timeout), .fuse_req(fuse_req), .fuse_addr(fuse_addr),
        .fuse_rdy(fuse_rdy), .fuse_rdata(fuse_rdata), .pwr_wmask(pwr_wmask),
        .pwr_en_a(pwr_en_a), .pwr_en_b(pwr_en_b), .pwr_iso(pwr_iso)
    );

    int errs = 0, checks = 0;
    bit finished = 0;

    function automatic logic [7:0] fb(input logic [AW-1:0] a);
        logic [7:0] r;
        r = a[7:0] * 8'd7 + 8'd3;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------- fuse controller model ----------
    int m_lat = 1;
    bit m_stk = 0;
    logic [AW-1:0] m_stuck = '0;
    logic m_armed;
    int m_cnt;
    logic [AW-1:0] m_addr;
    logic [7:0] m_word;
    assign fuse_rdata = m_word;

    initial begin
        fuse_rdy = 1'b1; m_word = 8'hEE; m_armed = 1'b0; m_cnt = 0; m_addr = '0;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                fuse_rdy <= 1'b1; m_word <= 8'hEE; m_armed <= 1'b0; m_cnt <= 0;
            end else if (fuse_req) begin
                m_addr  <= fuse_addr;
                m_cnt   <= m_lat;
                m_armed <= !(m_stk && fuse_addr == m_stuck);
                if (m_lat == 0 && !(m_stk && fuse_addr == m_stuck)) begin
                    fuse_rdy <= 1'b1; m_word <= fb(fuse_addr);
                end else begin
                    fuse_rdy <= 1'b0; m_word <= 8'hEE;
                end
            end else if (m_armed && !fuse_rdy) begin
                if (m_cnt <= 1) begin
                    fuse_rdy <= 1'b1; m_word <= fb(m_addr);
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    // ---------- monitor (negedge) ----------
    int cyc = 0;
    int t_start, t_mask_up, t_a_up, t_b_up, t_iso_dn, t_first_req, t_last_req;
    int t_last_byte, t_iso_up, t_b_dn, t_a_dn, t_mask_dn, t_done;
    int nbytes, nreq, ndone, bad_req, pwr_edges;
    logic got_err;
    bit off_at_done;
    logic [7:0] got [256];
    logic p_mask = 0, p_a = 0, p_b = 0, p_iso = 1;

    task automatic clear_mon();
        t_start = -1; t_mask_up = -1; t_a_up = -1; t_b_up = -1; t_iso_dn = -1;
        t_first_req = -1; t_last_req = -1; t_last_byte = -1; t_iso_up = -1;
        t_b_dn = -1; t_a_dn = -1; t_mask_dn = -1; t_done = -1;
        nbytes = 0; nreq = 0; ndone = 0; bad_req = 0; pwr_edges = 0;
        got_err = 1'b0; off_at_done = 1'b0;
    endtask

    initial begin
        clear_mon();
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (req_start && t_start < 0) t_start = cyc;
                if (pwr_wmask && !p_mask) t_mask_up = cyc;
                if (!pwr_wmask && p_mask) t_mask_dn = cyc;
                if (pwr_en_a && !p_a) t_a_up = cyc;
                if (!pwr_en_a && p_a) t_a_dn = cyc;
                if (pwr_en_b && !p_b) t_b_up = cyc;
                if (!pwr_en_b && p_b) t_b_dn = cyc;
                if (!pwr_iso && p_iso) t_iso_dn = cyc;
                if (pwr_iso && !p_iso) t_iso_up = cyc;
                if (pwr_wmask != p_mask || pwr_en_a != p_a || pwr_en_b != p_b || pwr_iso != p_iso)
                    pwr_edges++;
                if (fuse_req) begin
                    if (t_first_req < 0) t_first_req = cyc;
                    t_last_req = cyc;
                    nreq++;
                    if (pwr_iso || !pwr_en_b) bad_req++;
                end
                if (byte_valid) begin
                    if (nbytes < 256) got[nbytes] = byte_data;
                    nbytes++;
                    t_last_byte = cyc;
                end
                if (done) begin
                    ndone++;
                    t_done = cyc;
                    got_err = err_timeout;
                    off_at_done = pwr_iso && !pwr_en_a && !pwr_en_b && !pwr_wmask;
                end
            end
            p_mask = pwr_wmask; p_a = pwr_en_a; p_b = pwr_en_b; p_iso = pwr_iso;
        end
    end

    // ---------- driver tasks ----------
    task automatic issue(input logic [AW-1:0] a, input logic [LW-1:0] n);
        @(posedge clk); #1;
        req_start = 1'b1; req_addr = a; req_len = n;
        @(posedge clk); #1;
        req_start = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (ndone == 0 && k < 5000) begin
            @(posedge clk); #1;
            k++;
        end
        if (ndone == 0) chk(1'b0, "R5", "watchdog: no done", 0, 1);
        repeat (4) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic check_power(input bit had_bytes, input bit err_exp);
        chk(t_mask_up == t_start + 2, "R2", "wmask rise cycle", t_mask_up - t_start, 2);
        chk(t_a_up == t_mask_up + 1, "R2", "stage A after wmask", t_a_up - t_mask_up, 1);
        chk(t_b_up == t_a_up + ST + 1, "R2", "stage B after A", t_b_up - t_a_up, ST + 1);
        chk(t_iso_dn == t_b_up + 1, "R2", "iso release after B", t_iso_dn - t_b_up, 1);
        chk(t_first_req == t_iso_dn, "R2", "first request cycle", t_first_req, t_iso_dn);
        chk(t_b_dn == t_iso_up + 1, "R5", "B drop after iso", t_b_dn - t_iso_up, 1);
        chk(t_a_dn == t_b_dn + ST + 1, "R5", "A drop after B", t_a_dn - t_b_dn, ST + 1);
        chk(t_mask_dn == t_a_dn + 1, "R5", "wmask drop after A", t_mask_dn - t_a_dn, 1);
        chk(t_done == t_mask_dn + 1, "R5", "done after wmask drop", t_done - t_mask_dn, 1);
        chk(off_at_done, "R5", "power off at done", off_at_done, 1);
        if (err_exp)
            chk(t_iso_up == t_last_req + PL + 2, "R6", "iso after timed-out request", t_iso_up - t_last_req, PL + 2);
        else if (had_bytes)
            chk(t_iso_up == t_last_byte + 1, "R5", "iso after last byte", t_iso_up - t_last_byte, 1);
    endtask

    task automatic check_bytes(input logic [AW-1:0] a, input int n_exp, input string req);
        int mism;
        mism = 0;
        chk(nbytes == n_exp, req, "byte count", nbytes, n_exp);
        for (int i = 0; i < n_exp && i < nbytes; i++) begin
            logic [AW-1:0] ai;
            ai = a + AW'(i);
            if (got[i] !== fb(ai)) begin
                if (mism == 0) chk(1'b0, req, "byte value", got[i], fb(ai));
                mism++;
            end
        end
        if (mism == 0) chk(1'b1, req, "byte values", 0, 0);
    endtask

    // ---------- main ----------
    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 0 && byte_valid == 0 && done == 0 && err_timeout == 0 && fuse_req == 0,
            "R1", "control outputs in reset", {busy, byte_valid, done, err_timeout, fuse_req}, 0);
        chk(pwr_wmask == 0 && pwr_en_a == 0 && pwr_en_b == 0 && pwr_iso == 1,
            "R1", "power outputs in reset", {pwr_wmask, pwr_en_a, pwr_en_b, pwr_iso}, 1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            int n, lat, so, n_exp;
            bit err_exp;
            a = VEC[v][33:24]; n = VEC[v][23:16]; lat = VEC[v][15:8]; so = VEC[v][7:0];
            m_lat = lat;
            m_stk = (so != 255);
            m_stuck = a + AW'(so);
            n_exp = n;
            if (so != 255 && so < n) n_exp = so;
            if (lat >= PL) n_exp = 0;
            err_exp = (n_exp < n);
            @(posedge clk); #1;
            clear_mon();
            issue(a, LW'(n));
            wait_done();
            check_bytes(a, n_exp, (lat == PL - 1) ? "R7" : "R4");
            chk(nreq == (err_exp ? n_exp + 1 : n_exp), "R4", "request count", nreq, err_exp ? n_exp + 1 : n_exp);
            chk(bad_req == 0, "R3", "requests while unpowered", bad_req, 0);
            chk(ndone == 1, "R5", "done pulses", ndone, 1);
            chk(got_err == err_exp, err_exp ? "R6" : "R10", "error flag at done", got_err, err_exp);
            check_power(n_exp > 0, err_exp);
        end

        // R8 zero-length request
        m_stk = 0; m_lat = 1;
        @(posedge clk); #1;
        clear_mon();
        issue(10'h077, 8'd0);
        wait_done();
        chk(t_done == t_start + 2, "R8", "zero-length done cycle", t_done - t_start, 2);
        chk(got_err == 0, "R8", "zero-length error flag", got_err, 0);
        chk(nreq == 0 && nbytes == 0, "R8", "zero-length fuse activity", nreq + nbytes, 0);
        chk(pwr_edges == 0, "R8", "zero-length power edges", pwr_edges, 0);

        // R9 start while busy
        m_lat = 4;
        @(posedge clk); #1;
        clear_mon();
        issue(10'h040, 8'd3);
        chk(busy == 1, "R9", "busy after start", busy, 1);
        repeat (ST + 8) @(posedge clk);
        #1;
        issue(10'h300, 8'd5);
        wait_done();
        check_bytes(10'h040, 3, "R9");
        chk(nreq == 3, "R9", "requests with second start", nreq, 3);
        chk(ndone == 1, "R9", "done pulses with second start", ndone, 1);
        chk(busy == 0, "R9", "busy after finish", busy, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            chk(1'b0, "R5", "global watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule